// File: doc/BRIEF.md
# Keyed Hardware-Write Unlock Gate

This block sits beside a small byte-wide register file. It holds two independent permissions that protect an attached flash part. The first is a hardware-write unlock. It opens only after a fixed six-byte key has been written, byte by byte and in order, to one key register. Writing zero to that register closes it again. The second is a register-write protection flag that a second register sets and clears.

The unlock state gates requests for page-window writes. The protection flag gates requests for flash status-register commands. Both states can be read back through a combinational read port. Writes to any other register pass through without touching the gate. They also do not disturb a key sequence that is part-way through.

Top module: `wlock_gate`

## Requirements
- R1: After reset the gate is locked and protection is on. Address 0xDA reads 0x00, address 0xB3 reads 0x00, and both grants are low.
- R2: Writing 0xAA, 0x55, 0x50, 0x41, 0x52, 0x44 in that order to address 0xDA unlocks the gate from the cycle after the write of the last byte.
- R3: A key that stops short of its sixth byte leaves the gate locked.
- R4: A byte written to 0xDA that does not match the next expected key byte restarts detection. If that byte is 0xAA, it counts as the first key byte of a new attempt.
- R5: Writes to addresses other than 0xDA, including 0xB3, leave the key progress and the unlock state unchanged.
- R6: Writing 0x00 to 0xDA locks the gate from the next cycle.
- R7: Writing 0x10 to 0xB3 turns protection off and writing 0x00 turns it on. Any other value written to 0xB3 is ignored.
- R8: `sts_cmd_grant` is high only while `sts_cmd_req` is high and protection is off. `page_wr_grant` is high only while `page_wr_req` is high and the gate is unlocked.
- R9: Reading 0xDA returns 0x01 when the gate is unlocked and 0x00 when it is locked. Reading 0xB3 returns 0x10 when protection is off and 0x00 when it is on. Every other address reads 0x00.
- R10: While the gate is unlocked, writing a nonzero byte to 0xDA leaves it unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Combinational read data |
| page_wr_req | input | 1 | Page-window write request |
| page_wr_grant | output | 1 | Page-window write permitted |
| sts_cmd_req | input | 1 | Flash status-register command request |
| sts_cmd_grant | output | 1 | Status-register command permitted |

## Verification
A wrong key-position counter shows up at the ports one cycle after the final key byte. At that point the gate either fails to open on a valid key or opens on a broken one. The scoreboard therefore compares both grants after every single register write. It does not only check at the end of a sequence. The sequences place restarts on 0xAA, foreign-register writes between key bytes, and relock writes so that a stale or mis-restarted counter changes the grant within a few writes. A wrong protection decode is visible on the status-command grant and on the 0xB3 readback in the cycle after the write.

// File: rtl/wlock_pkg.sv
package wlock_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned KEY_LEN = 6;

  function automatic logic [BYTE_W-1:0] key_byte(input int unsigned idx);
    case (idx)
      0:       key_byte = 8'hAA;
      1:       key_byte = 8'h55;
      2:       key_byte = 8'h50;
      3:       key_byte = 8'h41;
      4:       key_byte = 8'h52;
      5:       key_byte = 8'h44;
      default: key_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/wlock_key_seq.sv
module wlock_key_seq
  import wlock_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hDA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              unlocked
);
  localparam int unsigned IDX_W = $clog2(KEY_LEN + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_LEN - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             unl_q, unl_d;
  logic             key_hit;
  logic             state_en;
  logic [BYTE_W-1:0] expect_byte;

  assign key_hit     = wr_en && (wr_addr == KEY_ADDR);
  assign expect_byte = key_byte(int'(idx_q));
  assign state_en    = key_hit;

  // next-state: sequence position and lock flag
  always_comb begin
    idx_d = idx_q;
    unl_d = unl_q;
    if (unl_q) begin
      if (wr_data == '0) begin
        unl_d = 1'b0;
        idx_d = '0;
      end
    end else if (wr_data == expect_byte) begin
      if (idx_q == LAST_IDX) begin
        unl_d = 1'b1;
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else if (wr_data == key_byte(0)) begin
      idx_d = IDX_W'(1);
    end else begin
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      unl_q <= 1'b0;
    end else if (state_en) begin
      idx_q <= idx_d;
      unl_q <= unl_d;
    end
  end

  assign unlocked = unl_q;
endmodule

// File: rtl/wlock_prot_reg.sv
module wlock_prot_reg
  import wlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 8'hB3,
  parameter logic [BYTE_W-1:0] OFF_CODE  = 8'h10,
  parameter logic [BYTE_W-1:0] ON_CODE   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              prot_off
);
  logic off_q, off_d, off_en;
  logic prot_hit;

  assign prot_hit = wr_en && (wr_addr == PROT_ADDR);

  always_comb begin
    off_d  = off_q;
    off_en = 1'b0;
    if (prot_hit && (wr_data == OFF_CODE)) begin
      off_d  = 1'b1;
      off_en = 1'b1;
    end else if (prot_hit && (wr_data == ON_CODE)) begin
      off_d  = 1'b0;
      off_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= 1'b0;
    else if (off_en) off_q <= off_d;
  end

  assign prot_off = off_q;
endmodule

// File: rtl/wlock_readback.sv
module wlock_readback
  import wlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hDA,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 8'hB3,
  parameter logic [BYTE_W-1:0] OFF_CODE  = 8'h10,
  parameter logic [BYTE_W-1:0] ON_CODE   = 8'h00
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              unlocked,
  input  logic              prot_off,
  output logic [BYTE_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == KEY_ADDR)       rd_data = {{(BYTE_W-1){1'b0}}, unlocked};
    else if (rd_addr == PROT_ADDR) rd_data = prot_off ? OFF_CODE : ON_CODE;
  end
endmodule

// File: rtl/wlock_gate.sv
module wlock_gate
  import wlock_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned RST_STAGES = 2,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hDA,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 8'hB3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              page_wr_req,
  output logic              page_wr_grant,
  input  logic              sts_cmd_req,
  output logic              sts_cmd_grant
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;
  logic                  unlock_q;
  logic                  prot_off_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  wlock_key_seq #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .unlocked(unlock_q)
  );

  wlock_prot_reg #(.ADDR_W(ADDR_W), .PROT_ADDR(PROT_ADDR)) u_prot (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prot_off(prot_off_q)
  );

  wlock_readback #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .PROT_ADDR(PROT_ADDR)) u_rb (
    .rd_addr(rd_addr), .unlocked(unlock_q), .prot_off(prot_off_q), .rd_data(rd_data)
  );

  assign page_wr_grant = page_wr_req & unlock_q;
  assign sts_cmd_grant = sts_cmd_req & prot_off_q;
endmodule

// File: rtl/wlock_gate_chk.sv
module wlock_gate_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hDA,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 8'hB3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              unlocked,
  input logic              prot_off
);
  assert_unlock_on_last_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en && wr_addr == KEY_ADDR && wr_data == 8'h44));

  assert_foreign_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != KEY_ADDR) |=> $stable(unlocked));

  assert_zero_relocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == KEY_ADDR && wr_data == 8'h00) |=> !unlocked);

  assert_prot_off_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == PROT_ADDR && wr_data == 8'h10) |=> prot_off);

  assert_prot_on_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == PROT_ADDR && wr_data == 8'h00) |=> !prot_off);

  assert_prot_other_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_addr == PROT_ADDR && (wr_data == 8'h10 || wr_data == 8'h00))) |=> $stable(prot_off));

  assert_nonzero_keeps_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_en && wr_addr == KEY_ADDR && wr_data != 8'h00) |=> unlocked);
endmodule

bind wlock_gate wlock_gate_chk #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .PROT_ADDR(PROT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .unlocked(unlock_q), .prot_off(prot_off_q)
);

// File: tb/wlock_gate_tb_top.sv
module wlock_gate_tb_top;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic       page_wr_req, page_wr_grant, sts_cmd_req, sts_cmd_grant;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct { logic unl; logic poff; string tag; } exp_t;
  exp_t sb_q[$];

  localparam logic [7:0] KA = 8'hDA;
  localparam logic [7:0] PA = 8'hB3;

  wlock_gate dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .page_wr_req(page_wr_req),
    .page_wr_grant(page_wr_grant), .sts_cmd_req(sts_cmd_req), .sts_cmd_grant(sts_cmd_grant)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one register write, then queue the expected gate state
  task automatic wr(input logic [7:0] a, input logic [7:0] d,
                    input logic eu, input logic ep, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    e.unl = eu; e.poff = ep; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares grants one half cycle after each write lands
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk({e.tag, " page grant"}, {7'd0, page_wr_grant}, {7'd0, e.unl & page_wr_req});
      chk({e.tag, " status grant"}, {7'd0, sts_cmd_grant}, {7'd0, e.poff & sts_cmd_req});
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    #2 chk(tag, rd_data, exp);
  endtask

  task automatic key(input logic ep, input string tag);
    wr(KA, 8'hAA, 0, ep, tag); wr(KA, 8'h55, 0, ep, tag); wr(KA, 8'h50, 0, ep, tag);
    wr(KA, 8'h41, 0, ep, tag); wr(KA, 8'h52, 0, ep, tag); wr(KA, 8'h44, 1, ep, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    page_wr_req = 1'b1; sts_cmd_req = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(KA, 8'h00, "R1 key reg after reset");
    rd(PA, 8'h00, "R1 prot reg after reset");
    chk("R1 page grant after reset", {7'd0, page_wr_grant}, 8'h00);
    chk("R1 status grant after reset", {7'd0, sts_cmd_grant}, 8'h00);
    // R3 short key, then broken by zero
    wr(KA, 8'hAA, 0, 0, "R3"); wr(KA, 8'h55, 0, 0, "R3"); wr(KA, 8'h50, 0, 0, "R3");
    wr(KA, 8'h41, 0, 0, "R3"); wr(KA, 8'h52, 0, 0, "R3"); wr(KA, 8'h00, 0, 0, "R3");
    wr(KA, 8'h44, 0, 0, "R3 lone last byte");
    // R2 full key
    key(0, "R2");
    rd(KA, 8'h01, "R9 key reg unlocked");
    rd(8'h20, 8'h00, "R9 other address");
    @(negedge clk); page_wr_req = 1'b0;
    #2 chk("R8 page grant without request", {7'd0, page_wr_grant}, 8'h00);
    @(negedge clk); page_wr_req = 1'b1;
    // R10 nonzero keeps open
    wr(KA, 8'h37, 1, 0, "R10"); wr(KA, 8'hAA, 1, 0, "R10");
    // R6 relock
    wr(KA, 8'h00, 0, 0, "R6");
    rd(KA, 8'h00, "R9 key reg relocked");
    // R4 restart on AA
    wr(KA, 8'hAA, 0, 0, "R4"); wr(KA, 8'h55, 0, 0, "R4");
    key(0, "R4 restart on AA");
    wr(KA, 8'h00, 0, 0, "R6 relock again");
    // R4 restart on non-AA byte
    wr(KA, 8'hAA, 0, 0, "R4"); wr(KA, 8'h55, 0, 0, "R4"); wr(KA, 8'h50, 0, 0, "R4");
    wr(KA, 8'h13, 0, 0, "R4"); wr(KA, 8'h55, 0, 0, "R4"); wr(KA, 8'h50, 0, 0, "R4");
    wr(KA, 8'h41, 0, 0, "R4"); wr(KA, 8'h52, 0, 0, "R4"); wr(KA, 8'h44, 0, 0, "R4 no unlock");
    // R5 foreign writes interleaved
    wr(KA, 8'hAA, 0, 0, "R5"); wr(KA, 8'h55, 0, 0, "R5");
    wr(PA, 8'h10, 0, 1, "R5 R7 prot off"); wr(KA, 8'h50, 0, 1, "R5");
    wr(8'h20, 8'hFF, 0, 1, "R5 foreign"); wr(KA, 8'h41, 0, 1, "R5");
    wr(KA, 8'h52, 0, 1, "R5"); wr(KA, 8'h44, 1, 1, "R5 unlock");
    wr(8'h41, 8'h00, 1, 1, "R5 foreign zero");
    rd(PA, 8'h10, "R9 prot reg off");
    // R7 other codes ignored, then on
    wr(PA, 8'h77, 1, 1, "R7 ignored code");
    @(negedge clk); sts_cmd_req = 1'b0;
    #2 chk("R8 status grant without request", {7'd0, sts_cmd_grant}, 8'h00);
    @(negedge clk); sts_cmd_req = 1'b1;
    wr(PA, 8'h00, 1, 0, "R7 prot on");
    wr(PA, 8'h10, 1, 1, "R7 prot off again");
    wr(PA, 8'h00, 1, 0, "R7 prot on again");
    rd(PA, 8'h00, "R9 prot reg on");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule